// File: doc/BRIEF.md
# Serial Port Baud Clock and Interrupt Gate

This block produces the oversampling clock enable for a full-duplex asynchronous serial port and combines its two interrupt sources. The system clock first goes through a fractional prescaler. Its factor is set in half steps, so half-integer factors are available: a 4.608 MHz input with a factor of 2.5 gives a 1.8432 MHz reference. A programmable divisor then divides the reference into a one-cycle tick at sixteen times the bit rate. Software writes the divisor as the divide value minus one, so 383 selects 300 baud from the 1.8432 MHz reference, 191 selects 600 baud and 1046 selects 110 baud.

The receive side reports a full buffer and the transmit side reports an empty buffer. Each status flag drives its own interrupt line through its own enable bit. Software reaches the divisor, the prescaler factor and the two enables through a small byte-wide register port. Writes are synchronous and reads are combinational.

Top module: `serbaud_top`

## Requirements
- R1: After reset, all four registers read 0, except the prescaler register, which reads 2 (factor 1). Both interrupt lines are low whatever the status inputs are.
- R2: The prescaler field H (address 2, bits 4:0) sets the factor to H/2 input cycles per reference pulse. Any value of H below 2 acts as 2. When H is odd, the pulses come alternately floor(H/2) and ceil(H/2) cycles apart.
- R3: With divisor register value D and N = D+1, the time from any tick to the second tick after it is exactly N*H input clock cycles, with H taken as in R2.
- R4: The 11-bit divisor register is split over two addresses. Address 0 holds bits 7:0 and address 1, bits 2:0, holds bits 10:8. Both read back as written, and bits 7:3 of address 1 read 0.
- R5: Writing either divisor byte restarts the divide count from the new value. The next tick then follows within N*ceil(H/2)+4 cycles of the write, however long the old divisor was.
- R6: When N is at least 2, a tick lasts exactly one clock cycle.
- R7: The receive interrupt is high exactly when the receive-full input is high and the receive enable (address 3, bit 0) is set.
- R8: The transmit interrupt is high exactly when the transmit-empty input is high and the transmit enable (address 3, bit 1) is set. It does not depend on the receive side.
- R9: The prescaler register reads back in bits 4:0 with bits 7:5 at 0. The enable register reads back in bits 1:0 with bits 7:2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| rx_full | input | 1 | Receive buffer holds a character |
| tx_empty | input | 1 | Transmit buffer can take a character |
| baud_tick | output | 1 | Oversampling tick, 16x the bit rate |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The assertions assume that software changes the prescaler factor and the divisor only through the register port. They also assume that a changed value reaches the counters as a reload on the following cycle. The bounds on the accumulator and the divide count hold only outside those reload cycles. The status inputs are taken as free-running levels, because the interrupt gate has no state. The stimulus changes configuration only by register writes at the falling edge. It discards the first tick after each change, and random divisors and factors are kept small enough that each two-tick window ends well inside the run.

// File: rtl/serbaud_pkg.sv
package serbaud_pkg;
  typedef enum logic [1:0] {
    ADR_DIV_LO = 2'd0,
    ADR_DIV_HI = 2'd1,
    ADR_PRESC  = 2'd2,
    ADR_IRQEN  = 2'd3
  } serbaud_adr_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned EN_RX  = 0;
  localparam int unsigned EN_TX  = 1;
endpackage

// File: rtl/serbaud_regs.sv
module serbaud_regs
  import serbaud_pkg::*;
#(
  parameter int unsigned DIV_W  = 11,
  parameter int unsigned HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [DIV_W-1:0]  div_o,
  output logic [HALF_W-1:0] half_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              div_load_o,
  output logic              presc_clr_o
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [1:0]        en_q, en_d;
  logic              load_q, load_d;
  logic              clr_q, clr_d;
  serbaud_adr_e      adr;

  assign adr = serbaud_adr_e'(addr);

  always_comb begin
    div_d  = div_q;
    half_d = half_q;
    en_d   = en_q;
    load_d = 1'b0;
    clr_d  = 1'b0;
    if (wr) begin
      unique case (adr)
        ADR_DIV_LO: begin
          div_d[BYTE_W-1:0] = wdata;
          load_d = 1'b1;
        end
        ADR_DIV_HI: begin
          div_d[DIV_W-1:BYTE_W] = wdata[HI_W-1:0];
          load_d = 1'b1;
        end
        ADR_PRESC: begin
          half_d = wdata[HALF_W-1:0];
          clr_d  = 1'b1;
        end
        ADR_IRQEN: en_d = wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= HALF_W'(2);
      en_q   <= '0;
      load_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      half_q <= half_d;
      en_q   <= en_d;
      load_q <= load_d;
      clr_q  <= clr_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (adr)
      ADR_DIV_LO: rdata = div_q[BYTE_W-1:0];
      ADR_DIV_HI: rdata[HI_W-1:0] = div_q[DIV_W-1:BYTE_W];
      ADR_PRESC:  rdata[HALF_W-1:0] = half_q;
      ADR_IRQEN:  rdata[1:0] = en_q;
      default: ;
    endcase
  end

  assign div_o       = div_q;
  assign half_o      = half_q;
  assign rx_en_o     = en_q[EN_RX];
  assign tx_en_o     = en_q[EN_TX];
  assign div_load_o  = load_q;
  assign presc_clr_o = clr_q;

  AST_LOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (adr == ADR_DIV_LO || adr == ADR_DIV_HI)) |=> div_load_o) // R5
    else $error("divisor write did not request a reload");
endmodule

// File: rtl/serbaud_prescale.sv
module serbaud_prescale #(
  parameter int unsigned HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_i,
  input  logic              clr_i,
  output logic              ref_o
);
  localparam int unsigned ACC_W = HALF_W + 1;

  logic [ACC_W-1:0] eff;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum;
  logic             ref_q, ref_d;

  // factor below one is raised to one
  assign eff = (half_i < HALF_W'(2)) ? ACC_W'(2) : ACC_W'(half_i);
  assign sum = acc_q + ACC_W'(2);

  always_comb begin
    acc_d = sum;
    ref_d = 1'b0;
    if (clr_i) begin
      acc_d = '0;
    end else if (sum >= eff) begin
      acc_d = sum - eff;
      ref_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ref_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ref_q <= ref_d;
    end
  end

  assign ref_o = ref_q;

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> (acc_q < eff)) // R2
    else $error("prescale accumulator out of range");

  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q && !clr_i && half_i >= HALF_W'(4)) |=> !ref_q) // R2
    else $error("reference pulses too close");
endmodule

// File: rtl/serbaud_divider.sv
module serbaud_divider #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (load_i) begin
      cnt_d = div_i;
    end else if (ref_i) begin
      if (cnt_zero) begin
        cnt_d  = div_i;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |-> (cnt_q <= div_i)) // R5
    else $error("divide count above divisor");

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && div_i != '0 && !load_i) |=> !tick_q) // R6
    else $error("tick wider than one cycle");
endmodule

// File: rtl/serbaud_irq.sv
module serbaud_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_full_i,
  input  logic tx_empty_i,
  input  logic rx_en_i,
  input  logic tx_en_i,
  output logic rx_irq_o,
  output logic tx_irq_o
);
  assign rx_irq_o = rx_full_i & rx_en_i;
  assign tx_irq_o = tx_empty_i & tx_en_i;

  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |-> !rx_irq_o) // R7
    else $error("receive interrupt while disabled");

  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> !tx_irq_o) // R8
    else $error("transmit interrupt while disabled");
endmodule

// File: rtl/serbaud_top.sv
module serbaud_top #(
  parameter int unsigned DIV_W  = 11,
  parameter int unsigned HALF_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_full,
  input  logic       tx_empty,
  output logic       baud_tick,
  output logic       rx_irq,
  output logic       tx_irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [DIV_W-1:0]  div;
  logic [HALF_W-1:0] half;
  logic              rx_en, tx_en, div_load, presc_clr, ref_pulse;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  serbaud_regs #(.DIV_W(DIV_W), .HALF_W(HALF_W)) i_regs (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .div_o(div), .half_o(half),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .div_load_o(div_load),
    .presc_clr_o(presc_clr)
  );

  serbaud_prescale #(.HALF_W(HALF_W)) i_presc (
    .clk(clk), .rst_n(rst_n_s), .half_i(half), .clr_i(presc_clr),
    .ref_o(ref_pulse)
  );

  serbaud_divider #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n_s), .ref_i(ref_pulse), .load_i(div_load),
    .div_i(div), .tick_o(baud_tick)
  );

  serbaud_irq i_irq (
    .clk(clk), .rst_n(rst_n_s), .rx_full_i(rx_full), .tx_empty_i(tx_empty),
    .rx_en_i(rx_en), .tx_en_i(tx_en), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );
endmodule

// File: tb/test_serbaud_top.sv
module test_serbaud_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_full = 1'b0, tx_empty = 1'b0;
  logic       baud_tick, rx_irq, tx_irq;

  int total = 0;
  int bad = 0;
  int unsigned cyc = 0;
  int unsigned seed = 32'd7719;

  serbaud_top i_serbaud_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_full(rx_full),
    .tx_empty(tx_empty), .baud_tick(baud_tick), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int eff_half(input int h);
    return (h < 2) ? 2 : h;
  endfunction

  function automatic int two_tick_gap(input int d, input int h);
    return (d + 1) * eff_half(h);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_div(input int d);
    wr(2'd1, 8'((d >> 8) & 7));
    wr(2'd0, 8'(d & 255));
  endtask

  task automatic wait_tick(output int unsigned t);
    do @(negedge clk); while (!baud_tick);
    t = cyc;
  endtask

  task automatic measure(input int d, input int h, input string req);
    int unsigned t0, t1, t2;
    wait_tick(t0);
    wait_tick(t0);
    wait_tick(t1);
    wait_tick(t2);
    check(req, int'(t2 - t0), two_tick_gap(d, h));
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 div lo", v, 0);
    rd(2'd1, v); check("R1 div hi", v, 0);
    rd(2'd2, v); check("R1 presc", v, 2);
    rd(2'd3, v); check("R1 irq en", v, 0);
    rx_full = 1'b1; tx_empty = 1'b1; #1;
    check("R1 irqs", {30'd0, rx_irq, tx_irq}, 0);

    // R4 / R9 register read-back
    wr(2'd0, 8'hA5); wr(2'd1, 8'hFF);
    rd(2'd0, v); check("R4 lo", v, 8'hA5);
    rd(2'd1, v); check("R4 hi", v, 7);
    wr(2'd2, 8'hF3);
    rd(2'd2, v); check("R9 presc", v, 8'h13);
    wr(2'd3, 8'hFE);
    rd(2'd3, v); check("R9 en", v, 2);

    // R3 datasheet-like: factor 2.5, 300 baud divisor
    wr(2'd2, 8'd5); set_div(383);
    measure(383, 5, "R3 f2.5 d383");
    wr(2'd2, 8'd2); set_div(1046);
    measure(1046, 2, "R3 f1 d1046");
    // R2 factor below one treated as one
    wr(2'd2, 8'd0); set_div(4);
    measure(4, 0, "R2 h0");
    wr(2'd2, 8'd1); set_div(0);
    measure(0, 1, "R2 h1 d0");
    wr(2'd2, 8'd7); set_div(0);
    measure(0, 7, "R2 h7 d0");

    // R6 single-cycle tick
    wr(2'd2, 8'd2); set_div(3);
    for (int k = 0; k < 3; k++) begin
      int unsigned t;
      wait_tick(t);
      @(negedge clk);
      check("R6 tick width", int'(baud_tick), 0);
    end

    // R5 reload on write
    wr(2'd2, 8'd4); set_div(2000);
    repeat (40) @(negedge clk);
    begin
      int unsigned tw, tt;
      set_div(9);
      tw = cyc;
      wait_tick(tt);
      check("R5 reload bound", int'((tt - tw) <= 9 * 0 + 10 * 2 + 4), 1);
    end

    // R3 random
    for (int k = 0; k < 20; k++) begin
      int d, h;
      d = int'($urandom(seed) % 40); seed = seed * 69069 + 1;
      h = int'($urandom(seed) % 13); seed = seed * 69069 + 1;
      wr(2'd2, 8'(h)); set_div(d);
      measure(d, h, "R3 random");
    end

    // R7 / R8 interrupt gating
    for (int k = 0; k < 24; k++) begin
      logic [1:0] en;
      en = 2'($urandom(seed)); seed = seed * 69069 + 1;
      wr(2'd3, {6'd0, en});
      rx_full  = 1'($urandom(seed)); seed = seed * 69069 + 1;
      tx_empty = 1'($urandom(seed)); seed = seed * 69069 + 1;
      #1;
      check("R7 rx irq", int'(rx_irq), int'(rx_full & en[0]));
      check("R8 tx irq", int'(tx_irq), int'(tx_empty & en[1]));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule